// File: doc/BRIEF.md
# T1 Robbed-Bit Signaling Extractor

This block recovers per-channel signaling from a received DS1 stream that has already been framed upstream. Each incoming beat carries one channel byte, the index of the channel it belongs to and the index of the frame within the superframe. In the designated signaling frames the block takes the least significant bit of each channel byte, where a robbed signaling bit sits, and files it under the channel's A, B, C or D signaling slot. Both the 12-frame superframe and the 24-frame extended superframe are handled. A mode pin selects between them.

Captured bits first land in a per-channel shadow store. At the last beat of each complete superframe, the whole shadow store is copied into the readable bank in a single step, so a reader never sees a mix of two superframes. A global enable pin and a per-channel clear-channel vector gate extraction. A channel marked clear carries data only, and its signaling is left untouched. The readable bank is read through a simple address port with a one-cycle latency.

The input stream follows valid/ready rules. A beat is taken on every rising clock edge where `in_valid` and `in_ready` are both high. `in_ready` drops only while reset is asserted, so out of reset the block never applies back-pressure, and an upstream source may stream one beat per cycle without interruption.

Top module: `rbs_extractor`

## Requirements
- R1: While and after synchronous reset, every readable signaling register and `rd_data` read as zero, and `in_ready` is low during reset and high otherwise.
- R2: The A bit (register bit 3) of a channel is taken from `in_byte[0]`, the eighth and last transmitted bit of the channel byte, in frame 6 of the superframe.
- R3: The B bit (register bit 2) is taken from `in_byte[0]` in frame 12.
- R4: In extended mode (`fmt_esf`=1), the C bit (register bit 1) is taken in frame 18 and the D bit (register bit 0) in frame 24, and the bank updates after the beat of channel 23 in frame 24.
- R5: In 12-frame mode (`fmt_esf`=0), the bank updates after the beat of channel 23 in frame 12. C and D are never captured in this mode, so they keep their earlier values.
- R6: While `rbs_en` is 0, no signaling bit is captured, and the registers keep their values across superframe updates.
- R7: A channel whose `clear_chan` bit is 1 captures no signaling, and its register keeps its earlier value.
- R8: The readable bank changes only in the cycle that follows a superframe's final beat, and all channels update together at that point.
- R9: Read address 0x70+n returns channel n (n = 0..23) as {12'b0, A, B, C, D} one clock after the address is presented. Any other address returns zero.
- R10: Only a beat with `in_valid` and `in_ready` both high has any effect. A beat with a channel index of 24 or above is ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Channel beat valid |
| in_ready | output | 1 | Beat accepted when high together with in_valid |
| in_byte | input | 8 | Received channel byte; bit 0 is the robbed bit |
| in_chan | input | 5 | Channel index, 0 to 23 |
| in_frame | input | 5 | Frame index in the superframe, starting at 1 |
| fmt_esf | input | 1 | 1 = 24-frame extended superframe, 0 = 12-frame superframe |
| rbs_en | input | 1 | Global enable for signaling extraction |
| clear_chan | input | 24 | Per-channel clear-channel flag; 1 disables extraction |
| rd_addr | input | 8 | Register read address |
| rd_data | output | 16 | Registered read data |

## Verification
The bench builds the block with its default parameters: 24 channels, a 12-frame short superframe, a 24-frame extended superframe and a register base of 0x70. These values expose every channel register, including the addresses just below and just above the bank. They also put the final-channel, final-frame update beat of both formats within reach of the stimulus, and bring the switch from extended to short mode into play, where C and D must survive. Superframes are replayed with several masking patterns and seeds. The bench interrupts a superframe halfway to check that no partial update is visible, and it withholds the final beat's valid to check that the update waits.

// File: rtl/rbs_pkg.sv
package rbs_pkg;

  typedef enum logic [1:0] {
    SLOT_A = 2'd0,
    SLOT_B = 2'd1,
    SLOT_C = 2'd2,
    SLOT_D = 2'd3
  } sig_slot_e;

  // a sits in bit 3 and d in bit 0 of the readable nibble
  typedef struct packed {
    logic a;
    logic b;
    logic c;
    logic d;
  } sig_bits_t;

  localparam int unsigned SIG_W = 4;

endpackage

// File: rtl/rbs_frame_decode.sv
module rbs_frame_decode
  import rbs_pkg::*;
#(
  parameter int unsigned NCH        = 24,
  parameter int unsigned SF_LEN_D4  = 12,
  parameter int unsigned SF_LEN_ESF = 24,
  parameter int unsigned CW         = 5,
  parameter int unsigned FW         = 5
) (
  input  logic          beat,
  input  logic [FW-1:0] frame,
  input  logic [CW-1:0] chan,
  input  logic          fmt_esf,
  output logic          slot_hit,
  output sig_slot_e     slot,
  output logic          commit
);

  localparam int unsigned A_FR = SF_LEN_D4 / 2;
  localparam int unsigned B_FR = SF_LEN_D4;
  localparam int unsigned C_FR = SF_LEN_D4 + SF_LEN_D4 / 2;
  localparam int unsigned D_FR = SF_LEN_ESF;

  logic          chan_ok;
  logic [FW-1:0] last_fr;

  always_comb begin
    chan_ok  = ({1'b0, chan} < (CW+1)'(NCH));
    last_fr  = fmt_esf ? FW'(SF_LEN_ESF) : FW'(SF_LEN_D4);
    slot_hit = 1'b0;
    slot     = SLOT_A;
    if (beat && chan_ok) begin
      if (frame == FW'(A_FR)) begin
        slot_hit = 1'b1;
        slot     = SLOT_A;
      end else if (frame == FW'(B_FR)) begin
        slot_hit = 1'b1;
        slot     = SLOT_B;
      end else if (fmt_esf && frame == FW'(C_FR)) begin
        slot_hit = 1'b1;
        slot     = SLOT_C;
      end else if (fmt_esf && frame == FW'(D_FR)) begin
        slot_hit = 1'b1;
        slot     = SLOT_D;
      end
    end
    commit = beat && (chan == CW'(NCH - 1)) && (frame == last_fr);
  end

endmodule

// File: rtl/rbs_shadow_bank.sv
module rbs_shadow_bank
  import rbs_pkg::*;
#(
  parameter int unsigned NCH = 24,
  parameter int unsigned CW  = 5
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               slot_hit,
  input  sig_slot_e          slot,
  input  logic [CW-1:0]      chan,
  input  logic               lsb,
  input  logic               rbs_en,
  input  logic [NCH-1:0]     clear_chan,
  input  logic               commit,
  output logic [NCH*SIG_W-1:0] shadow_q,
  output logic [NCH*SIG_W-1:0] vis_q
);

  for (genvar g = 0; g < NCH; g++) begin : g_chan
    sig_bits_t sh_q, sh_d, vis_r;
    logic      wr;

    assign wr = slot_hit && rbs_en && !clear_chan[g] && (chan == CW'(g));

    always_comb begin
      sh_d = sh_q;
      if (wr) begin
        case (slot)
          SLOT_A:  sh_d.a = lsb;
          SLOT_B:  sh_d.b = lsb;
          SLOT_C:  sh_d.c = lsb;
          default: sh_d.d = lsb;
        endcase
      end
    end

    always_ff @(posedge clk) begin
      if (rst) sh_q <= '0;
      else     sh_q <= sh_d;
    end

    // the final beat's own capture is included in the transfer
    always_ff @(posedge clk) begin
      if (rst)         vis_r <= '0;
      else if (commit) vis_r <= sh_d;
    end

    assign shadow_q[g*SIG_W +: SIG_W] = sh_q;
    assign vis_q[g*SIG_W +: SIG_W]    = vis_r;
  end

endmodule

// File: rtl/rbs_read_port.sv
module rbs_read_port
  import rbs_pkg::*;
#(
  parameter int unsigned NCH     = 24,
  parameter int unsigned AW      = 8,
  parameter int unsigned DW      = 16,
  parameter int unsigned RD_BASE = 'h70
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [AW-1:0]        rd_addr,
  input  logic [NCH*SIG_W-1:0] vis_q,
  output logic [DW-1:0]        rd_data
);

  logic [AW-1:0]    off;
  logic             in_bank;
  logic [SIG_W-1:0] sel;

  always_comb begin
    off     = rd_addr - AW'(RD_BASE);
    in_bank = (rd_addr >= AW'(RD_BASE)) && (off < AW'(NCH));
    sel     = '0;
    for (int i = 0; i < NCH; i++) begin
      if (in_bank && off == AW'(i)) sel = vis_q[i*SIG_W +: SIG_W];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) rd_data <= '0;
    else     rd_data <= DW'(sel);
  end

endmodule

// File: rtl/rbs_extractor.sv
module rbs_extractor
  import rbs_pkg::*;
#(
  parameter int unsigned NCH        = 24,
  parameter int unsigned SF_LEN_D4  = 12,
  parameter int unsigned SF_LEN_ESF = 24,
  parameter int unsigned AW         = 8,
  parameter int unsigned DW         = 16,
  parameter int unsigned RD_BASE    = 'h70,
  localparam int unsigned CW        = $clog2(NCH),
  localparam int unsigned FW        = $clog2(SF_LEN_ESF + 1)
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           in_valid,
  output logic           in_ready,
  input  logic [7:0]     in_byte,
  input  logic [CW-1:0]  in_chan,
  input  logic [FW-1:0]  in_frame,
  input  logic           fmt_esf,
  input  logic           rbs_en,
  input  logic [NCH-1:0] clear_chan,
  input  logic [AW-1:0]  rd_addr,
  output logic [DW-1:0]  rd_data
);

  logic                 beat;
  logic                 slot_hit;
  sig_slot_e            slot;
  logic                 commit;
  logic [NCH*SIG_W-1:0] shadow_q;
  logic [NCH*SIG_W-1:0] vis_q;

  assign in_ready = !rst;
  assign beat     = in_valid && in_ready;

  rbs_frame_decode #(
    .NCH(NCH), .SF_LEN_D4(SF_LEN_D4), .SF_LEN_ESF(SF_LEN_ESF), .CW(CW), .FW(FW)
  ) u_dec (
    .beat(beat), .frame(in_frame), .chan(in_chan), .fmt_esf(fmt_esf),
    .slot_hit(slot_hit), .slot(slot), .commit(commit)
  );

  rbs_shadow_bank #(.NCH(NCH), .CW(CW)) u_bank (
    .clk(clk), .rst(rst), .slot_hit(slot_hit), .slot(slot), .chan(in_chan),
    .lsb(in_byte[0]), .rbs_en(rbs_en), .clear_chan(clear_chan),
    .commit(commit), .shadow_q(shadow_q), .vis_q(vis_q)
  );

  rbs_read_port #(.NCH(NCH), .AW(AW), .DW(DW), .RD_BASE(RD_BASE)) u_rd (
    .clk(clk), .rst(rst), .rd_addr(rd_addr), .vis_q(vis_q), .rd_data(rd_data)
  );

endmodule

// File: rtl/rbs_extractor_chk.sv
module rbs_extractor_chk #(
  parameter int unsigned NCH        = 24,
  parameter int unsigned SF_LEN_D4  = 12,
  parameter int unsigned AW         = 8,
  parameter int unsigned DW         = 16,
  parameter int unsigned RD_BASE    = 'h70,
  parameter int unsigned CW         = 5,
  parameter int unsigned FW         = 5
) (
  input logic           clk,
  input logic           rst,
  input logic           in_valid,
  input logic           in_ready,
  input logic [7:0]     in_byte,
  input logic [CW-1:0]  in_chan,
  input logic [FW-1:0]  in_frame,
  input logic           fmt_esf,
  input logic           rbs_en,
  input logic [NCH-1:0] clear_chan,
  input logic [AW-1:0]  rd_addr,
  input logic [DW-1:0]  rd_data,
  input logic           commit,
  input logic [NCH*4-1:0] shadow_q,
  input logic [NCH*4-1:0] vis_q
);

  localparam logic [NCH*4-1:0] CD_MASK = {NCH{4'b0011}};

  logic addr_in_bank;
  assign addr_in_bank = (32'(rd_addr) >= RD_BASE) && (32'(rd_addr) < RD_BASE + NCH);

  assert_hold_until_commit_R8: assert property (@(posedge clk) disable iff (rst)
    !commit |=> $stable(vis_q));

  assert_outside_reads_zero_R9: assert property (@(posedge clk) disable iff (rst)
    !addr_in_bank |=> (rd_data == '0));

  assert_short_mode_keeps_cd_R5: assert property (@(posedge clk) disable iff (rst)
    !fmt_esf |=> ((shadow_q & CD_MASK) == ($past(shadow_q) & CD_MASK)));

  assert_disabled_no_capture_R6: assert property (@(posedge clk) disable iff (rst)
    !rbs_en |=> $stable(shadow_q));

  assert_bad_chan_ignored_R10: assert property (@(posedge clk) disable iff (rst)
    (32'(in_chan) >= NCH) |=> $stable(shadow_q));

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    assert_clear_holds_R7: assert property (@(posedge clk) disable iff (rst)
      clear_chan[g] |=> $stable(shadow_q[g*4 +: 4]));

    assert_a_capture_R2: assert property (@(posedge clk) disable iff (rst)
      (in_valid && in_ready && rbs_en && !clear_chan[g] && in_chan == CW'(g)
       && in_frame == FW'(SF_LEN_D4 / 2))
      |=> (shadow_q[g*4 + 3] == $past(in_byte[0])));
  end

endmodule

bind rbs_extractor rbs_extractor_chk #(
  .NCH(NCH), .SF_LEN_D4(SF_LEN_D4), .AW(AW), .DW(DW), .RD_BASE(RD_BASE),
  .CW(CW), .FW(FW)
) u_chk (
  .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
  .in_byte(in_byte), .in_chan(in_chan), .in_frame(in_frame),
  .fmt_esf(fmt_esf), .rbs_en(rbs_en), .clear_chan(clear_chan),
  .rd_addr(rd_addr), .rd_data(rd_data), .commit(commit),
  .shadow_q(shadow_q), .vis_q(vis_q)
);

// File: tb/rbs_extractor_test.sv
`timescale 1ns/1ps
module rbs_extractor_test;

  typedef struct packed {
    logic        esf;
    logic        en;
    logic [23:0] clr;
    logic [7:0]  seed;
  } vec_t;

  localparam int NV = 7;
  localparam vec_t VECS [NV] = '{
    '{esf:1'b1, en:1'b1, clr:24'h000000, seed:8'h5A},
    '{esf:1'b1, en:1'b1, clr:24'h800081, seed:8'hC3},
    '{esf:1'b0, en:1'b1, clr:24'h000000, seed:8'h3C},
    '{esf:1'b0, en:1'b1, clr:24'h00F00F, seed:8'h99},
    '{esf:1'b1, en:1'b0, clr:24'h000000, seed:8'h11},
    '{esf:1'b1, en:1'b1, clr:24'hFFFFFF, seed:8'h77},
    '{esf:1'b1, en:1'b1, clr:24'h0F0F0F, seed:8'hE4}
  };

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [7:0]  in_byte = '0;
  logic [4:0]  in_chan = '0;
  logic [4:0]  in_frame = 5'd1;
  logic        fmt_esf = 1'b1;
  logic        rbs_en = 1'b1;
  logic [23:0] clear_chan = '0;
  logic [7:0]  rd_addr = '0;
  logic [15:0] rd_data;

  int checks = 0;
  int fails  = 0;
  logic [3:0] pend [24];
  logic [3:0] vis  [24];

  always #2.5 clk = ~clk;

  rbs_extractor uut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .in_byte(in_byte), .in_chan(in_chan), .in_frame(in_frame),
    .fmt_esf(fmt_esf), .rbs_en(rbs_en), .clear_chan(clear_chan),
    .rd_addr(rd_addr), .rd_data(rd_data)
  );

  function automatic logic [7:0] bgen(input logic [7:0] s, input int f, input int c);
    logic [7:0] ff, cc;
    ff = 8'(f);
    cc = 8'(c);
    return s ^ (ff * 8'd29) ^ (cc * cc * 8'd3) ^ {cc[0], ff[1], 6'd0} ^ {7'd0, ff[2] & cc[1]};
  endfunction

  task automatic check(input bit ok, input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic beat(input bit v, input int f, input int c, input logic [7:0] b);
    @(negedge clk);
    in_valid = v;
    in_frame = 5'(f);
    in_chan  = 5'(c);
    in_byte  = b;
    if (v && c < 24) begin
      if (rbs_en && !clear_chan[c]) begin
        if (f == 6)             pend[c][3] = b[0];
        if (f == 12)            pend[c][2] = b[0];
        if (fmt_esf && f == 18) pend[c][1] = b[0];
        if (fmt_esf && f == 24) pend[c][0] = b[0];
      end
      if (c == 23 && f == (fmt_esf ? 24 : 12))
        for (int k = 0; k < 24; k++) vis[k] = pend[k];
    end
  endtask

  task automatic frames(input logic [7:0] s, input int f0, input int f1, input bit extra);
    for (int f = f0; f <= f1; f++) begin
      for (int c = 0; c < 24; c++) beat(1'b1, f, c, bgen(s, f, c));
      if (extra) begin
        beat(1'b1, f, 24, 8'hFF);
        beat(1'b1, f, 31, 8'hFF);
      end
    end
  endtask

  task automatic rd_chk(input int addr, input logic [15:0] exp, input string req);
    @(negedge clk);
    in_valid = 1'b0;
    rd_addr  = 8'(addr);
    @(negedge clk);
    check(rd_data == exp, req, rd_data, exp);
  endtask

  task automatic sweep(input string req);
    for (int c = 0; c < 24; c++) rd_chk('h70 + c, {12'd0, vis[c]}, req);
  endtask

  initial begin
    #1_000_000;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    for (int k = 0; k < 24; k++) begin
      pend[k] = '0;
      vis[k]  = '0;
    end
    repeat (4) @(negedge clk);
    check(in_ready == 1'b0, "R1 ready low in reset", {15'd0, in_ready}, 16'd0);
    rst = 1'b0;
    @(negedge clk);
    check(in_ready == 1'b1, "R10 ready after reset", {15'd0, in_ready}, 16'd1);
    // R1: cleared bank
    rd_chk('h70, 16'd0, "R1");
    rd_chk('h7C, 16'd0, "R1");
    rd_chk('h87, 16'd0, "R1");

    // vector table: R2 R3 R4 R5 R6 R7
    for (int v = 0; v < NV; v++) begin
      @(negedge clk);
      fmt_esf    = VECS[v].esf;
      rbs_en     = VECS[v].en;
      clear_chan = VECS[v].clr;
      frames(VECS[v].seed, 1, VECS[v].esf ? 24 : 12, 1'b0);
      sweep(VECS[v].esf ? "R2/R3/R4/R6/R7 extended" : "R2/R3/R5/R7 short");
    end

    // R9: addresses around the bank
    rd_chk('h6F, 16'd0, "R9 below base");
    rd_chk('h88, 16'd0, "R9 above bank");
    rd_chk('h00, 16'd0, "R9 zero address");

    // R8: half a superframe must not show
    @(negedge clk);
    fmt_esf = 1'b1; rbs_en = 1'b1; clear_chan = '0;
    frames(8'hA7, 1, 12, 1'b0);
    rd_chk('h73, {12'd0, vis[3]}, "R8 mid superframe");
    rd_chk('h78, {12'd0, vis[8]}, "R8 mid superframe");
    frames(8'hA7, 13, 24, 1'b0);
    sweep("R8 after update");

    // R10: final beat withheld, then delivered
    frames(8'h2B, 1, 23, 1'b0);
    for (int c = 0; c < 23; c++) beat(1'b1, 24, c, bgen(8'h2B, 24, c));
    beat(1'b0, 24, 23, 8'hFF);
    rd_chk('h85, {12'd0, vis[21]}, "R10 invalid final beat");
    beat(1'b1, 24, 23, bgen(8'h2B, 24, 23));
    sweep("R10 final beat delivered");

    // R10: out-of-range channel indices mixed in
    frames(8'h6D, 1, 24, 1'b1);
    sweep("R10 channel above 23 ignored");

    // R5: short mode repeated twice within a 24-frame count
    @(negedge clk);
    fmt_esf = 1'b0;
    frames(8'h48, 1, 12, 1'b0);
    frames(8'hB5, 1, 12, 1'b0);
    sweep("R5 repeated short superframes");

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule